// File: doc/BRIEF.md
# Indirect Colour Table Access Port

This block gives a 32-bit host register bus a window onto three colour lookup tables (red, green and blue). Each table holds 32 rows of 64 bits. Software first writes a pointer register. That register holds a 6-bit half-row index and a 2-bit table select. Software then streams words through a single data register. The bus is narrower than a table row, so each row is reached as two half-rows. An even index is the lower 32 bits of row `index>>1` and an odd index is the upper 32 bits. Every access to the data register, read or write, moves the index on by one. Software therefore loads a start index once and then streams data.

Writes are gathered in pairs. The even-index word is held in a staging register. The table row changes only when the matching odd-index word arrives, and then the full 64 bits are committed at once. One select code broadcasts a committed row to all three tables. Under that code, reads come from the red table. Writing the pointer register discards any half-gathered pair, so every new stream starts clean.

Top module: `rgb_table_port`

## Requirements
- R1: After reset, both the pointer register and the data register read as zero, and `rdata_o` is zero.
- R2: The data register is at `addr_i`=1 and the pointer register is at `addr_i`=0. A pointer write stores `wdata_i[5:0]` as the index and `wdata_i[9:8]` as the select. A pointer read returns the index in bits 5:0 and the select in bits 9:8, with every other bit zero, whatever was written to those bits.
- R3: Each data-register read or write increments the index by one. The index wraps from 63 to 0.
- R4: A write at an even index followed by a write at the next (odd) index commits the 64-bit row {odd word, even word} to row `odd_index>>1`. A later read at an even index returns the lower 32 bits and a read at an odd index returns the upper 32 bits.
- R5: A write at an even index alone leaves every table row unchanged.
- R6: Select 00 commits a row to all three tables. Reads under select 00 return red-table contents.
- R7: Select 01 accesses only red, 10 only green and 11 only blue. A commit leaves the other two tables unchanged.
- R8: A pending even word is discarded by a pointer write or by a data read. An odd-index write with no pending even word commits nothing.
- R9: Read data appears on `rdata_o` one cycle after the read strobe and holds until the next read.
- R10: Pointer-register reads and cycles with no access leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 selects the pointer register, 1 selects the data register |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
Read data is due in the cycle after the strobe edge. The bench drives strobes on the falling edge and samples `rdata_o` at the next falling edge, so it always reads after the register has loaded. A committed row is visible to a read issued in the cycle after the second write, and the index is updated by the same edge as the access that increments it. The bench reference model applies every update at the same access boundary, and each expected value is compared only after the access that produces it. Rows that should stay untouched are checked by reading them back through the data register after the stimulus, including a full sweep of all three tables at the end.

// File: rtl/rgb_tbl_pkg.sv
package rgb_tbl_pkg;
  localparam int unsigned NUM_COLORS = 3;

  typedef enum logic [1:0] {
    SEL_ALL = 2'b00,
    SEL_RED = 2'b01,
    SEL_GRN = 2'b10,
    SEL_BLU = 2'b11
  } sel_e;

  // colour slot order in the table array
  localparam int unsigned C_RED = 0;
  localparam int unsigned C_GRN = 1;
  localparam int unsigned C_BLU = 2;
endpackage

// File: rtl/rgb_tbl_idx.sv
module rgb_tbl_idx
  import rgb_tbl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  sel_e             ld_sel_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output sel_e             sel_o
);
  logic [IDX_W-1:0] idx_q;
  sel_e             sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= SEL_ALL;
    end else if (ld_i) begin
      idx_q <= ld_idx_i;
      sel_q <= ld_sel_i;
    end else if (step_i) begin
      idx_q <= idx_q + IDX_W'(1);  // natural wrap
    end
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/rgb_tbl_accum.sv
module rgb_tbl_accum
  import rgb_tbl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic                  odd_i,
  input  sel_e                  sel_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [NUM_COLORS-1:0] commit_o,
  output logic [2*DATA_W-1:0]   row_o,
  output logic                  pend_o
);
  logic [DATA_W-1:0] lo_q;
  logic              pend_q;
  logic              fire;

  assign fire = wr_i & odd_i & pend_q;

  always_comb begin
    commit_o = '0;
    if (fire) begin
      unique case (sel_i)
        SEL_ALL: commit_o = '1;
        SEL_RED: commit_o[C_RED] = 1'b1;
        SEL_GRN: commit_o[C_GRN] = 1'b1;
        SEL_BLU: commit_o[C_BLU] = 1'b1;
        default: commit_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (wr_i) begin
      if (!odd_i) begin
        lo_q   <= wdata_i;
        pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign row_o  = {wdata_i, lo_q};
  assign pend_o = pend_q;
endmodule

// File: rtl/rgb_tbl_ram.sv
module rgb_tbl_ram #(
  parameter int unsigned ROW_W = 64,
  parameter int unsigned ROWS  = 32,
  localparam int unsigned AW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROW_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ROWS); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rgb_table_port.sv
module rgb_table_port
  import rgb_tbl_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ROWS    = 32,
  parameter int unsigned SEL_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned ROW_W  = 2 * DATA_W;
  localparam int unsigned IDX_W  = $clog2(2 * ROWS);
  localparam int unsigned ROW_AW = IDX_W - 1;

  logic wr_ptr, wr_dat, rd_ptr, rd_dat;
  assign wr_ptr = wr_en_i & ~addr_i;
  assign wr_dat = wr_en_i &  addr_i;
  assign rd_ptr = rd_en_i & ~wr_en_i & ~addr_i;  // write wins on collision
  assign rd_dat = rd_en_i & ~wr_en_i &  addr_i;

  logic [IDX_W-1:0] idx_q;
  sel_e             sel_q;

  rgb_tbl_idx #(.IDX_W(IDX_W)) i_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wr_ptr),
    .ld_idx_i (wdata_i[IDX_W-1:0]),
    .ld_sel_i (sel_e'(wdata_i[SEL_LSB +: 2])),
    .step_i   (wr_dat | rd_dat),
    .idx_o    (idx_q),
    .sel_o    (sel_q)
  );

  logic [NUM_COLORS-1:0] commit;
  logic [ROW_W-1:0]      new_row;
  logic                  pend;

  rgb_tbl_accum #(.DATA_W(DATA_W)) i_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wr_ptr | rd_dat),
    .wr_i     (wr_dat),
    .odd_i    (idx_q[0]),
    .sel_i    (sel_q),
    .wdata_i  (wdata_i),
    .commit_o (commit),
    .row_o    (new_row),
    .pend_o   (pend)
  );

  logic [ROW_AW-1:0] row_addr;
  logic [ROW_W-1:0]  tbl_q [NUM_COLORS];
  assign row_addr = idx_q[IDX_W-1:1];

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_tbl
    rgb_tbl_ram #(.ROW_W(ROW_W), .ROWS(ROWS)) i_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (commit[c]),
      .waddr_i (row_addr),
      .wdata_i (new_row),
      .raddr_i (row_addr),
      .rdata_o (tbl_q[c])
    );
  end

  logic [ROW_W-1:0]  rd_row;
  logic [DATA_W-1:0] rd_half, ptr_word, rdata_q;

  always_comb begin
    unique case (sel_q)
      SEL_GRN: rd_row = tbl_q[C_GRN];
      SEL_BLU: rd_row = tbl_q[C_BLU];
      default: rd_row = tbl_q[C_RED];  // SEL_ALL reads red
    endcase
    rd_half = idx_q[0] ? rd_row[ROW_W-1:DATA_W] : rd_row[DATA_W-1:0];
    ptr_word = '0;
    ptr_word[IDX_W-1:0]     = idx_q;
    ptr_word[SEL_LSB +: 2]  = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_dat) rdata_q <= rd_half;
    else if (rd_ptr) rdata_q <= ptr_word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rgb_table_port_chk.sv
module rgb_table_port_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned NC     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [IDX_W-1:0]  idx_i,
  input logic [1:0]        sel_i,
  input logic              pend_i,
  input logic [NC-1:0]     commit_i
);
  logic dat_acc, ptr_wr, ptr_rd;
  assign dat_acc = addr_i & (wr_en_i | rd_en_i);
  assign ptr_wr  = wr_en_i & ~addr_i;
  assign ptr_rd  = rd_en_i & ~wr_en_i & ~addr_i;

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_acc |=> idx_i == IDX_W'($past(idx_i) + IDX_W'(1)));

  p_idx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_rd || !(wr_en_i || rd_en_i)) |=> $stable(idx_i));

  p_ptr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> idx_i == $past(wdata_i[IDX_W-1:0]));

  p_commit_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_i) |-> (wr_en_i && addr_i && idx_i[0] && pend_i));

  p_even_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && !idx_i[0]) |-> commit_i == '0);

  p_single_dest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|commit_i) && sel_i != 2'b00) |-> $countones(commit_i) == 1);

  p_bcast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|commit_i) && sel_i == 2'b00) |-> &commit_i);

  p_pend_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> !pend_i);

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind rgb_table_port rgb_table_port_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .NC     (3)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .idx_i    (idx_q),
  .sel_i    (sel_q),
  .pend_i   (pend),
  .commit_i (commit)
);

// File: tb/test_rgb_table_port.sv
module test_rgb_table_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rgb_table_port i_rgb_table_port (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o
  );

  // reference model
  logic [63:0] m_tbl [3][32];
  logic [5:0]  m_idx;
  logic [1:0]  m_sel;
  logic        m_pend;
  logic [31:0] m_lo;

  function automatic int col_of(input logic [1:0] s);
    return (s == 2'b10) ? 1 : (s == 2'b11) ? 2 : 0;
  endfunction

  function automatic logic [31:0] exp_data();
    logic [63:0] r = m_tbl[col_of(m_sel)][m_idx[5:1]];
    return m_idx[0] ? r[63:32] : r[31:0];
  endfunction

  function automatic logic [31:0] exp_ptr();
    return {22'd0, m_sel, 2'd0, m_idx};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic a, input logic we, input logic re, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_en_i = we; rd_en_i = re; wdata_i = d;
    @(negedge clk_i);
    addr_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic wr_ptr(input logic [31:0] d);
    bus(1'b0, 1'b1, 1'b0, d);
    m_idx = d[5:0]; m_sel = d[9:8]; m_pend = 1'b0;
  endtask

  task automatic wr_dat(input logic [31:0] d);
    bus(1'b1, 1'b1, 1'b0, d);
    if (!m_idx[0]) begin
      m_lo = d; m_pend = 1'b1;
    end else begin
      if (m_pend) begin
        if (m_sel == 2'b00) begin
          for (int c = 0; c < 3; c++) m_tbl[c][m_idx[5:1]] = {d, m_lo};
        end else m_tbl[col_of(m_sel)][m_idx[5:1]] = {d, m_lo};
      end
      m_pend = 1'b0;
    end
    m_idx = m_idx + 6'd1;
  endtask

  task automatic rd_dat(input string req);
    logic [31:0] e = exp_data();
    bus(1'b1, 1'b0, 1'b1, '0);
    check(req, rdata_o, e);
    m_pend = 1'b0;
    m_idx = m_idx + 6'd1;
  endtask

  task automatic rd_ptr(input string req);
    bus(1'b0, 1'b0, 1'b1, '0);
    check(req, rdata_o, exp_ptr());
  endtask

  initial begin
    #2_000_000;  // 100,000 cycles
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int c = 0; c < 3; c++) for (int r = 0; r < 32; r++) m_tbl[c][r] = '0;
    m_idx = '0; m_sel = '0; m_pend = 1'b0; m_lo = '0;
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(negedge clk_i);
    check("R1 rdata after reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    rd_ptr("R1 pointer reset");
    wr_ptr(32'h0000_0000);
    rd_dat("R1 data reset");

    // R2: reserved bits ignored
    wr_ptr(32'hFFFF_FC25 & ~32'h0000_0300 | 32'h0000_0200);
    rd_ptr("R2 pointer fields");
    rd_ptr("R10 pointer read keeps index");

    // R4/R5: pair commit under red select
    wr_ptr(32'h0000_0104);
    wr_dat(32'hA5A5_0001);
    wr_ptr(32'h0000_0104);
    rd_dat("R5 even write alone");
    wr_ptr(32'h0000_0104);
    wr_dat(32'hA5A5_0001);
    wr_dat(32'h5A5A_0002);
    rd_ptr("R3 index after pair");
    wr_ptr(32'h0000_0104);
    rd_dat("R4 lower half");
    rd_dat("R4 upper half");

    // R6: broadcast, read back red
    wr_ptr(32'h0000_0010);
    wr_dat(32'h1111_2222);
    wr_dat(32'h3333_4444);
    wr_ptr(32'h0000_0010);
    rd_dat("R6 broadcast read red");
    wr_ptr(32'h0000_0210);
    rd_dat("R6 broadcast green");
    wr_ptr(32'h0000_0311);
    rd_dat("R6 broadcast blue");

    // R7: green-only
    wr_ptr(32'h0000_0210);
    wr_dat(32'hBEEF_0000);
    wr_dat(32'hBEEF_0001);
    wr_ptr(32'h0000_0110);
    rd_dat("R7 red untouched");
    wr_ptr(32'h0000_0311);
    rd_dat("R7 blue untouched");

    // R8: pending pair discarded
    wr_ptr(32'h0000_0120);
    wr_dat(32'hDEAD_0000);
    wr_ptr(32'h0000_0121);
    wr_dat(32'hDEAD_0001);
    wr_ptr(32'h0000_0120);
    rd_dat("R8 pointer write drops pair");
    wr_ptr(32'h0000_0122);
    wr_dat(32'hCAFE_0000);
    rd_dat("R8 read breaks pair");
    wr_ptr(32'h0000_0123);
    wr_dat(32'hCAFE_0001);
    wr_ptr(32'h0000_0122);
    rd_dat("R8 no commit after read");

    // R3: wrap 63 -> 0
    wr_ptr(32'h0000_033E);
    wr_dat(32'h7777_0000);
    wr_dat(32'h7777_0001);
    rd_ptr("R3 wrap to zero");
    wr_ptr(32'h0000_033F);
    rd_dat("R3 top row upper");

    // R9: rdata holds across other traffic
    wr_ptr(32'h0000_0104);
    rd_dat("R9 read one cycle later");
    held = rdata_o;
    wr_dat(32'h0BAD_F00D);
    wr_ptr(32'h0000_0000);
    check("R9 rdata held", rdata_o, held);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op == 0)      wr_ptr($urandom());
      else if (op <= 5) wr_dat($urandom());
      else if (op <= 8) rd_dat("R4 random read");
      else              rd_ptr("R2 random pointer read");
    end

    // full sweep of each table
    for (int s = 1; s < 4; s++) begin
      wr_ptr(32'(s) << 8);
      for (int k = 0; k < 64; k++) rd_dat("R7 sweep");
      rd_ptr("R3 sweep wrap");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule